// File: doc/BRIEF.md
# Shared-Counter Multichannel PWM Generator

This block drives several PWM outputs from a single counter. A clock divider with two cascaded stages sets how often the counter steps. The counter runs in one of two modes. In edge-aligned mode it counts up to a shared top value and then restarts at zero. In centre-aligned mode it climbs to the top value and then falls back to zero, so each period takes twice as long.

Each channel holds a level register that two events move. When the counter is at zero, one event fires. When the counter equals that channel's compare value, the other event fires. In up-counting, the zero event sets the level and the compare event clears it. In centre-aligned mode the two actions swap while the counter is falling, which keeps each pulse centred on the zero point. A per-channel invert bit flips the driven output.

A host configures the block through a simple write port. Writes that would leave a channel without a reachable compare event are refused and latch a sticky error flag. The counter value is always visible on an output port.

Top module: `pwm_shared_counter`

## Requirements
- R1: After reset the counter reads 0, every channel output is 0, the error flag is 0, the counter is halted, top is 255 and all compare values are 0.
- R2: Register 2 holds the first divider stage in bits [7:0] and the second stage in bits [15:8]. While running, the counter takes one step every (stage1+1)*(stage2+1) clocks.
- R3: With bit 1 of register 0 clear (edge-aligned), the counter steps 0,1,...,top and then returns to 0. It never exceeds top.
- R4: With bit 1 of register 0 set (centre-aligned), the counter steps 0,1,...,top,top-1,...,1 and then returns to 0, giving a period of 2*top steps.
- R5: In edge-aligned mode a channel's level is high for counter values below its compare value. A compare of 0 gives a constant low level. A compare equal to a non-zero top gives a constant high level. The output follows the counter value with one cycle of latency.
- R6: In centre-aligned mode the level is high for values below the compare value while counting up, and for values up to and including the compare value while counting down. This gives 2*compare high steps per period.
- R7: Bit 2+k of register 0 enables channel k, and a disabled channel drives 0. Bit 6+k inverts the output of enabled channel k.
- R8: A write to register 0, 1 (when accepted) or 2 clears the counter to 0. Only bit 0 of a register 0 write starts the counter, and writes to registers 1 and 2 leave it halted.
- R9: A write to compare register 4+k with a value above top is refused. That channel's compare is kept and the error flag is set.
- R10: A write to top (register 1) is refused, and sets the error flag, when any channel is enabled or when any stored compare value exceeds the new top.
- R11: The error flag stays set until any write to register 3 clears it.
- R12: A new compare value takes effect only when the counter is at 0. A write made mid-period changes nothing until the next zero.
- R13: count_o shows the counter value on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register index |
| wr_data | input | DATA_W (32) | Write data |
| count_o | output | CNT_W (32) | Current counter value |
| pwm_o | output | NUM_CH (4) | Channel outputs |
| err_o | output | 1 | Sticky refused-write flag |

## Verification
A write takes effect at the clock edge that samples it. The error flag and a counter clear are therefore visible in the following cycle. The counter changes at the edge that ends its divider window, and each output reflects the counter value one edge later, because the level register sits between them. The bench updates its model at the same edges the design uses and compares every output at the falling edge. Directed probes wait for a specific counter value on that falling edge before they read an output, so each probe sees the result for the counter value one cycle earlier.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   // Register indices (the compare block starts at REG_CMP0, one per channel)
   localparam int unsigned REG_CTRL   = 0;
   localparam int unsigned REG_TOP    = 1;
   localparam int unsigned REG_DIV    = 2;
   localparam int unsigned REG_ERRCLR = 3;
   localparam int unsigned REG_CMP0   = 4;
   // Number of cascaded divider stages feeding the counter
   localparam int unsigned DIV_STAGES = 2;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr_i,
   input  logic                       run_i,
   input  logic [STAGES-1:0][W-1:0]   lim_i,
   output logic                       tick_o
);
   logic [STAGES-1:0][W-1:0] cnt_q;
   logic [STAGES:0]          adv;
   logic [STAGES-1:0]        wrap;

   assign adv[0] = run_i;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      assign wrap[s]  = (cnt_q[s] == lim_i[s]);
      assign adv[s+1] = adv[s] && wrap[s];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cnt_q[s] <= '0;
         else if (clr_i)    cnt_q[s] <= '0;
         else if (adv[s])   cnt_q[s] <= wrap[s] ? '0 : cnt_q[s] + W'(1);
      end
   end

   assign tick_o = adv[STAGES];

   // R2: every stage has wrapped when the counter is told to step
   p_stages_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> cnt_q[STAGES-1] == '0);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         tick_i,
   input  logic         centre_i,
   input  logic [W-1:0] top_i,
   output logic [W-1:0] count_o,
   output logic         down_o
);
   logic [W-1:0] count_q, nxt_cnt;
   logic         down_q, nxt_down;

   always_comb begin
      if (down_q)                nxt_cnt = count_q - W'(1);
      else if (count_q >= top_i) nxt_cnt = '0;
      else                       nxt_cnt = count_q + W'(1);
      if (nxt_cnt == '0)                         nxt_down = 1'b0;
      else if (centre_i && (nxt_cnt == top_i))   nxt_down = 1'b1;
      else                                       nxt_down = down_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         down_q  <= 1'b0;
      end else if (clr_i) begin
         count_q <= '0;
         down_q  <= 1'b0;
      end else if (tick_i) begin
         count_q <= nxt_cnt;
         down_q  <= nxt_down;
      end
   end

   assign count_o = count_q;
   assign down_o  = down_q;

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i && !clr_i |=> $stable(count_q));
   p_edge_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i && !clr_i && !centre_i && (count_q >= top_i) |=> count_q == '0);
   p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= top_i);
   p_down_only_centre_r4: assert property (@(posedge clk) disable iff (!rst_n)
      down_q |-> centre_i);
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (count_q == '0) && !down_q);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] count_i,
   input  logic         down_i,
   input  logic         centre_i,
   input  logic [W-1:0] top_i,
   input  logic [W-1:0] cmp_pend_i,
   input  logic         en_i,
   input  logic         inv_i,
   output logic         pwm_o
);
   logic [W-1:0] act_q, eff;
   logic         lvl_q, lvl_d;
   logic         at_zero, at_match, ev_set, ev_clr;

   // The pending compare is adopted only while the counter sits at zero
   assign at_zero  = (count_i == '0);
   assign eff      = at_zero ? cmp_pend_i : act_q;
   // In edge mode a non-zero compare equal to top never clears (constant high)
   assign at_match = (count_i == eff) && (centre_i || (eff != top_i) || (eff == '0));
   assign ev_set   = down_i ? at_match : at_zero;
   assign ev_clr   = down_i ? at_zero  : at_match;

   always_comb begin
      if (ev_clr)      lvl_d = 1'b0;
      else if (ev_set) lvl_d = 1'b1;
      else             lvl_d = lvl_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
         lvl_q <= 1'b0;
      end else begin
         act_q <= eff;
         lvl_q <= lvl_d;
      end
   end

   assign pwm_o = en_i && (lvl_q ^ inv_i);

   p_cmp_at_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !at_zero |=> $stable(act_q));
endmodule

// File: rtl/pwm_shared_counter.sv
module pwm_shared_counter
   import pwm_pkg::*;
#(
   parameter int unsigned NUM_CH  = 4,
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned DIV_W   = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned RST_TOP = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  count_o,
   output logic [NUM_CH-1:0] pwm_o,
   output logic              err_o
);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_TOP    = ADDR_W'(REG_TOP);
   localparam logic [ADDR_W-1:0] A_DIV    = ADDR_W'(REG_DIV);
   localparam logic [ADDR_W-1:0] A_ERRCLR = ADDR_W'(REG_ERRCLR);
   localparam int unsigned       INV_LSB  = 2 + NUM_CH;

   if (NUM_CH < 1)                       begin : g_bad_ch   $error("NUM_CH must be at least 1"); end
   if (CNT_W < 2)                        begin : g_bad_cnt  $error("CNT_W must be at least 2"); end
   if (DATA_W < CNT_W)                   begin : g_bad_dw   $error("DATA_W narrower than CNT_W"); end
   if (DATA_W < 2 + 2*NUM_CH)            begin : g_bad_ctl  $error("DATA_W cannot hold control bits"); end
   if (DATA_W < DIV_STAGES*DIV_W)        begin : g_bad_div  $error("DATA_W cannot hold divider fields"); end
   if ((1 << ADDR_W) < REG_CMP0 + NUM_CH) begin : g_bad_aw $error("ADDR_W too small for register map"); end

   logic                       run_q, centre_q, err_q;
   logic [NUM_CH-1:0]          chen_q, inv_q;
   logic [CNT_W-1:0]           top_q;
   logic [DIV_STAGES-1:0][DIV_W-1:0] lim_q;
   logic [CNT_W-1:0]           cmp_pend_q [NUM_CH];
   logic [CNT_W-1:0]           wval;
   logic [NUM_CH-1:0]          wr_cmp;
   logic                       cmp_too_big, below_cmp, top_rej, cfg_clr, tick, down;
   logic                       unused_wdata;

   assign wval         = wr_data[CNT_W-1:0];
   assign unused_wdata = ^wr_data;
   assign cmp_too_big  = (wval > top_q);

   always_comb begin
      below_cmp = 1'b0;
      for (int k = 0; k < NUM_CH; k++)
         if (cmp_pend_q[k] > wval) below_cmp = 1'b1;
   end

   assign top_rej = (|chen_q) || below_cmp;
   assign cfg_clr = wr_en && ((wr_addr == A_CTRL) || (wr_addr == A_DIV) ||
                              ((wr_addr == A_TOP) && !top_rej));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         centre_q <= 1'b0;
         chen_q   <= '0;
         inv_q    <= '0;
         top_q    <= CNT_W'(RST_TOP);
         lim_q    <= '0;
         err_q    <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == A_CTRL) begin
            run_q    <= wr_data[0];
            centre_q <= wr_data[1];
            chen_q   <= wr_data[2 +: NUM_CH];
            inv_q    <= wr_data[INV_LSB +: NUM_CH];
         end else if (wr_addr == A_TOP) begin
            if (top_rej) err_q <= 1'b1;
            else begin
               top_q <= wval;
               run_q <= 1'b0;
            end
         end else if (wr_addr == A_DIV) begin
            for (int s = 0; s < DIV_STAGES; s++) lim_q[s] <= wr_data[s*DIV_W +: DIV_W];
            run_q <= 1'b0;
         end else if (wr_addr == A_ERRCLR) begin
            err_q <= 1'b0;
         end else if ((|wr_cmp) && cmp_too_big) begin
            err_q <= 1'b1;
         end
      end
   end

   pwm_prescaler #(.STAGES(DIV_STAGES), .W(DIV_W)) u_prescaler (
      .clk(clk), .rst_n(rst_n), .clr_i(cfg_clr), .run_i(run_q),
      .lim_i(lim_q), .tick_o(tick));

   pwm_counter #(.W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .clr_i(cfg_clr), .tick_i(tick),
      .centre_i(centre_q), .top_i(top_q), .count_o(count_o), .down_o(down));

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      assign wr_cmp[k] = wr_en && (wr_addr == ADDR_W'(REG_CMP0 + k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          cmp_pend_q[k] <= '0;
         else if (wr_cmp[k] && !cmp_too_big)  cmp_pend_q[k] <= wval;
      end

      pwm_channel #(.W(CNT_W)) u_channel (
         .clk(clk), .rst_n(rst_n), .count_i(count_o), .down_i(down),
         .centre_i(centre_q), .top_i(top_q), .cmp_pend_i(cmp_pend_q[k]),
         .en_i(chen_q[k]), .inv_i(inv_q[k]), .pwm_o(pwm_o[k]));

      p_cmp_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
         wr_cmp[k] && cmp_too_big |=> err_q && $stable(cmp_pend_q[k]));
   end

   assign err_o = err_q;

   p_top_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (wr_addr == A_TOP) && (|chen_q) |=> err_q && $stable(top_q));
   p_err_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (wr_addr == A_ERRCLR) |=> !err_q);
   p_run_from_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> $past(wr_en && (wr_addr == A_CTRL)));
endmodule

// File: tb/pwm_shared_counter_bench.sv
module pwm_shared_counter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   wire  [31:0] count_o;
   wire  [3:0]  pwm_o;
   wire         err_o;

   int    checks = 0, errors = 0;
   string phase = "R1";
   bit    cmp_on = 1'b0, done = 1'b0;

   always #4 clk = ~clk;

   pwm_shared_counter u_pwm_shared_counter (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .count_o(count_o), .pwm_o(pwm_o), .err_o(err_o));

   // ---------------- behavioural reference model ----------------
   longint m_top, m_el, m_pos, m_pend[4], m_act[4];
   int     m_div, m_pre;
   bit     m_run, m_centre, m_err;
   bit [3:0] m_chen, m_inv, m_lvl;

   function automatic longint m_count();
      if (m_centre) begin
         if (m_top == 0) return 0;
         return (m_pos <= m_top) ? m_pos : 2*m_top - m_pos;
      end
      return m_pos;
   endfunction

   function automatic bit m_down();
      return m_centre && (m_top > 0) && (m_pos >= m_top);
   endfunction

   function automatic longint m_len();
      if (m_centre) return (m_top == 0) ? 1 : 2*m_top;
      return m_top + 1;
   endfunction

   longint mc, md, meff, mper;
   bit     mdn, mclr, mtick, mold_run, mbad;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_top = 255; m_el = 0; m_pos = 0; m_div = 0; m_pre = 0;
         m_run = 0; m_centre = 0; m_err = 0; m_chen = 0; m_inv = 0; m_lvl = 0;
         for (int k = 0; k < 4; k++) begin m_pend[k] = 0; m_act[k] = 0; end
      end else begin
         mc = m_count(); mdn = m_down();
         for (int k = 0; k < 4; k++) begin
            meff = (mc == 0) ? m_pend[k] : m_act[k];
            if (m_centre) m_lvl[k] = mdn ? (mc <= meff) : (mc < meff);
            else          m_lvl[k] = (meff != 0) && ((meff == m_top) || (mc < meff));
            m_act[k] = meff;
         end
         mper = longint'((m_div + 1) * (m_pre + 1));
         mtick = m_run && ((m_el % mper) == mper - 1);
         mold_run = m_run;
         mclr = 0;
         md = longint'(wr_data);
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin
                  m_run = wr_data[0]; m_centre = wr_data[1];
                  m_chen = wr_data[5:2]; m_inv = wr_data[9:6]; mclr = 1;
               end
               3'd1: begin
                  mbad = (m_chen != 0);
                  for (int k = 0; k < 4; k++) if (m_pend[k] > md) mbad = 1;
                  if (mbad) m_err = 1;
                  else begin m_top = md; m_run = 0; mclr = 1; end
               end
               3'd2: begin
                  m_div = int'(wr_data[7:0]); m_pre = int'(wr_data[15:8]);
                  m_run = 0; mclr = 1;
               end
               3'd3: m_err = 0;
               default: begin
                  if (md > m_top) m_err = 1;
                  else m_pend[int'(wr_addr) - 4] = md;
               end
            endcase
         end
         if (mclr) begin m_el = 0; m_pos = 0; end
         else if (mold_run) begin
            if (mtick) m_pos = (m_pos + 1) % m_len();
            m_el++;
         end
      end
   end

   // ---------------- checking ----------------
   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && cmp_on && !done) begin
         check(longint'(count_o) == m_count(), phase, "count_o (R13)",
               longint'(count_o), m_count());
         check(pwm_o == (m_chen & (m_lvl ^ m_inv)), phase, "pwm_o",
               longint'(pwm_o), longint'(m_chen & (m_lvl ^ m_inv)));
         check(err_o == m_err, phase, "err_o", longint'(err_o), longint'(m_err));
      end
   end

   task automatic wr(input int a, input longint d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[31:0];
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_count(input longint v);
      for (int i = 0; i < 400 && longint'(count_o) != v; i++) @(negedge clk);
   endtask

   task automatic wait_change();
      logic [31:0] prev;
      prev = count_o;
      for (int i = 0; i < 400 && count_o == prev; i++) @(negedge clk);
   endtask

   initial begin
      int n, hi0, hi1, hi2, hi3, lo2;
      logic [31:0] prev;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      check(count_o == 0, "R1", "count after reset", longint'(count_o), 0);
      check(pwm_o == 0,   "R1", "pwm after reset", longint'(pwm_o), 0);
      check(err_o == 0,   "R1", "err after reset", longint'(err_o), 0);
      cmp_on = 1'b1;

      // Edge mode, divider 2 x 3 = 6 clocks per step
      phase = "R2/R3/R5/R7";
      wr(2, 32'h0201);
      wr(1, 9);
      wr(4, 3); wr(5, 0); wr(6, 9); wr(7, 5);
      wr(0, 1 | (4'hF << 2) | (4'h8 << 6));
      idle(20);
      wait_change();
      prev = count_o; n = 0;
      do begin @(negedge clk); n++; end while (count_o == prev && n < 100);
      check(n == 6, "R2", "clocks per counter step", n, 6);
      wait_count(9); wait_change();
      check(count_o == 0, "R3", "value after top", longint'(count_o), 0);
      hi1 = 0; lo2 = 0;
      for (int i = 0; i < 130; i++) begin
         @(negedge clk);
         if (pwm_o[1]) hi1++;
         if (!pwm_o[2]) lo2++;
      end
      check(hi1 == 0, "R5", "compare 0 high cycles", hi1, 0);
      check(lo2 == 0, "R5", "compare==top low cycles", lo2, 0);

      // Refused writes and the sticky flag
      phase = "R9/R10/R11";
      wr(1, 20);
      check(err_o == 1, "R10", "top write while enabled", longint'(err_o), 1);
      wr(3, 0);
      check(err_o == 0, "R11", "error clear", longint'(err_o), 0);
      wr(4, 20);
      check(err_o == 1, "R9", "compare above top", longint'(err_o), 1);
      idle(30);
      check(err_o == 1, "R11", "flag stays set", longint'(err_o), 1);
      wr(3, 0);

      // Divider write halts and clears
      phase = "R8";
      wr(2, 0);
      check(count_o == 0, "R8", "count after divider write", longint'(count_o), 0);
      idle(5);
      check(count_o == 0, "R8", "counter halted after divider write", longint'(count_o), 0);

      phase = "R5/R12";
      wr(0, 1 | (4'hF << 2) | (4'h8 << 6));
      idle(15);
      hi0 = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (pwm_o[0]) hi0++; end
      check(hi0 == 3, "R5", "edge high cycles for compare 3", hi0, 3);
      wait_count(5);
      wr(4, 7);
      check(pwm_o[0] == 0, "R12", "mid-period compare not yet applied",
            longint'(pwm_o[0]), 0);
      wait_count(0); wait_count(6);
      check(pwm_o[0] == 1, "R12", "new compare after zero", longint'(pwm_o[0]), 1);

      // Centre-aligned mode, one step per clock
      phase = "R4/R6/R7";
      wr(4, 3);
      wr(0, 3 | (4'hF << 2) | (4'h8 << 6));
      idle(40);
      wait_count(9); wait_change();
      check(count_o == 8, "R4", "value after top in centre mode", longint'(count_o), 8);
      hi0 = 0; hi3 = 0;
      for (int i = 0; i < 18; i++) begin
         @(negedge clk);
         if (pwm_o[0]) hi0++;
         if (pwm_o[3]) hi3++;
      end
      check(hi0 == 6, "R6", "centre high steps for compare 3", hi0, 6);
      check(hi3 == 8, "R7", "inverted centre high steps for compare 5", hi3, 8);

      phase = "R8";
      wr(0, 2 | (4'hF << 2) | (4'h8 << 6));
      idle(20);
      check(count_o == 0, "R8", "halted by control write", longint'(count_o), 0);

      // Top change rules
      phase = "R10/R3/R7";
      wr(0, 0);
      wr(1, 4);
      check(err_o == 1, "R10", "top below stored compare", longint'(err_o), 1);
      wr(3, 0);
      wr(4, 2); wr(6, 4); wr(7, 4);
      wr(1, 4);
      check(err_o == 0, "R10", "top write accepted", longint'(err_o), 0);
      check(count_o == 0, "R8", "count after top write", longint'(count_o), 0);
      wr(0, 1 | (4'hF << 2));
      idle(50);
      wr(0, 1 | (4'hE << 2));
      hi2 = 0; hi0 = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (pwm_o[0]) hi0++;
         if (pwm_o[2]) hi2++;
      end
      check(hi0 == 0, "R7", "disabled channel high cycles", hi0, 0);
      check(hi2 >= 29, "R5", "compare==top stays high", hi2, 30);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule